// File: doc/BRIEF.md
# One-time-programmable byte memory with mode decoding

This block is a synthesizable behavioural model of a byte-wide one-time-programmable memory. Four control levels select what the memory does: an active-low chip select, an active-low output gate, a flag that says the programming supply is raised, and a flag that says the identifier voltage is on the address line that requests the signature. From these levels the block reads a stored byte, floats the data bus, takes a programming byte, reports a stored byte for verification, or returns one of two fixed identifier bytes. The array is a small register file whose depth is a parameter. It stands in for a full-size part.

The pins are plain levels, sampled on the system clock. The host owns all timing, so there is no valid/ready pair and no back-pressure. A byte is offered only while the mode allows it, and it is never held back. A high-impedance bus is modelled by a separate drive-enable output next to the data bus. When the drive enable is low, the data bus is held at zero.

Cells leave reset at all ones. A program pulse can only clear bits. The write takes effect when the chip select rises at the end of a low pulse made while the supply flag is high and the output gate is high. It happens once per pulse and uses the address and data present in the last low cycle.

Top module: `otp_byte_store`

## Requirements
- R1: With the supply flag low, the identifier flag low, and chip select and output gate both low, `dout_oe` is 1 and `dout` equals the byte stored at `addr` in the same cycle.
- R2: With the supply flag low, chip select low and the output gate high, `dout_oe` is 0.
- R3: With the supply flag low and chip select high, `dout_oe` is 0 whatever the output gate is.
- R4: With the supply flag high and the output gate high, a chip-select low pulse of one or more cycles ends when chip select returns high while the supply flag is still high. In that cycle the byte at the address held in the pulse's last low cycle becomes its old value ANDed with the data held in that cycle. It is updated once per pulse, and the bus is not driven during the pulse.
- R5: With the supply flag high, chip select high and the output gate low, `dout_oe` is 1 and `dout` equals the byte stored at `addr`.
- R6: With the supply flag high and chip select and output gate both high, `dout_oe` is 0 and no byte changes, except for the one update in the cycle that ends a pulse.
- R7: With the supply flag low, the identifier flag high, and chip select and output gate both low, `dout_oe` is 1. `dout` is 0x20 when `addr[0]` is 0 and 0xB4 when `addr[0]` is 1, and all other address bits are ignored.
- R8: After reset every stored byte reads 0xFF.
- R9: Programming never turns a 0 bit back to 1. A second pulse to the same address leaves the AND of both data bytes with the erased value.
- R10: Whenever `dout_oe` is 0, `dout` is 0.
- R11: With the supply flag high and chip select and output gate both low, `dout_oe` is 0. A pulse whose last low cycle is of this kind, or has the supply flag low, writes nothing when chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset; erases the array to all ones |
| ce_n | input | 1 | Active-low chip select (program pulse line) |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming supply is at its raised level |
| id_volt | input | 1 | Identifier voltage present on the signature-request address line |
| addr | input | AW | Byte address, AW = clog2(DEPTH) |
| din | input | 8 | Programming data |
| dout | output | 8 | Data bus value, zero when not driven |
| dout_oe | output | 1 | Data bus drive enable; 0 stands for high impedance |

## Verification
On every cycle, the assertions check four things. The bus stays undriven in standby, output-disable, inhibit and raised-supply-idle modes. An undriven bus reads zero. The signature codes follow `addr[0]`. A byte read twice at one address never gains a 1 bit. Inside the array and the pulse tracker they also check that a write only clears bits, comes only after a low chip-select cycle, and happens at most once per pulse. The bench scenarios are the only evidence for several other behaviours: that the stored values follow a reference image through program, reprogram and verify sequences; that a long pulse writes exactly its last address and data; that an aborted pulse leaves its byte erased; and that neighbouring addresses and the last address behave as expected.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OM_STANDBY,
    OM_READ,
    OM_OUT_OFF,
    OM_SIGNATURE,
    OM_PROGRAM,
    OM_VERIFY,
    OM_INHIBIT,
    OM_HV_IDLE
  } otp_mode_e;

  localparam logic [BYTE_W-1:0] SIG_CODE_EVEN = 8'h20;
  localparam logic [BYTE_W-1:0] SIG_CODE_ODD  = 8'hB4;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp_hi,
  input  logic      id_volt,
  output otp_mode_e mode
);
  always_comb begin
    if (vpp_hi) begin
      unique case ({ce_n, oe_n})
        2'b11:   mode = OM_INHIBIT;
        2'b10:   mode = OM_VERIFY;
        2'b01:   mode = OM_PROGRAM;
        default: mode = OM_HV_IDLE;
      endcase
    end else if (ce_n) begin
      mode = OM_STANDBY;
    end else if (oe_n) begin
      mode = OM_OUT_OFF;
    end else if (id_volt) begin
      mode = OM_SIGNATURE;
    end else begin
      mode = OM_READ;
    end
  end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  otp_mode_e         mode,
  input  logic              ce_n,
  input  logic              vpp_hi,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] din,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic              pulse_live;
  logic [AW-1:0]     hold_addr;
  logic [BYTE_W-1:0] hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_live <= 1'b0;
      hold_addr  <= '0;
      hold_data  <= '1;
    end else begin
      pulse_live <= (mode == OM_PROGRAM);
      if (mode == OM_PROGRAM) begin
        hold_addr <= addr;
        hold_data <= din;
      end
    end
  end

  // Write strobe: the chip select rises after a program cycle, supply still high.
  assign wr_en   = pulse_live && ce_n && vpp_hi;
  assign wr_addr = hold_addr;
  assign wr_data = hold_data;

  p_one_write_per_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_write_follows_low_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(ce_n) == 1'b0));
  p_no_write_without_supply_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_hi |-> !wr_en);
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '1;
      end else if (wr_en && (wr_addr == AW'(g))) begin
        q <= q & wr_data;
      end
    end
    assign cells[g] = q;
  end

  assign rd_data = cells[rd_addr];

  p_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cells[$past(wr_addr)] & ~$past(cells[wr_addr])) == '0));
  p_quiet_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (cells[$past(rd_addr)] == $past(rd_data)));
endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
  import otp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_volt,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_oe
);
  otp_mode_e         mode;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_data;
  logic [BYTE_W-1:0] sig_byte;

  otp_mode_dec u_dec (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_hi  (vpp_hi),
    .id_volt (id_volt),
    .mode    (mode)
  );

  otp_prog_seq #(.DEPTH(DEPTH)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .ce_n    (ce_n),
    .vpp_hi  (vpp_hi),
    .addr    (addr),
    .din     (din),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  otp_cell_array #(.DEPTH(DEPTH)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (addr),
    .rd_data (rd_data)
  );

  assign sig_byte = addr[0] ? SIG_CODE_ODD : SIG_CODE_EVEN;

  always_comb begin
    dout_oe = 1'b0;
    dout    = '0;
    unique case (mode)
      OM_READ, OM_VERIFY: begin
        dout_oe = 1'b1;
        dout    = rd_data;
      end
      OM_SIGNATURE: begin
        dout_oe = 1'b1;
        dout    = sig_byte;
      end
      default: ;
    endcase
  end

  logic plain_read;
  assign plain_read = !vpp_hi && !ce_n && !oe_n && !id_volt;

  p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_hi && !ce_n && oe_n) |-> !dout_oe);
  p_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_hi && ce_n) |-> !dout_oe);
  p_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && ce_n && oe_n) |-> !dout_oe);
  p_hv_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && !ce_n && !oe_n) |-> !dout_oe);
  p_sig_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_hi && !ce_n && !oe_n && id_volt) |->
      (dout_oe && (dout == (addr[0] ? 8'hB4 : 8'h20))));
  p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));
  p_no_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_read && $past(plain_read) && (addr == $past(addr))) |->
      ((dout & ~$past(dout)) == '0));
endmodule

// File: tb/otp_byte_store_tb_top.sv
module otp_byte_store_tb_top;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          vpp_hi = 1'b0;
  logic          id_volt = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] shadow [DEPTH];

  always #4 clk = ~clk;

  otp_byte_store #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_volt(id_volt), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic drive(logic e, logic g, logic v, logic idv, logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    ce_n = e; oe_n = g; vpp_hi = v; id_volt = idv; addr = a; din = d;
    #1;
  endtask

  task automatic read_at(string tag, logic [AW-1:0] a);
    drive(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
    chk({tag, " oe"}, {7'b0, dout_oe}, 8'h01);
    chk({tag, " data"}, dout, shadow[a]);
  endtask

  task automatic pulse(logic [AW-1:0] a, logic [7:0] d, int low_cycles);
    for (int i = 0; i < low_cycles; i++) begin
      drive(1'b0, 1'b1, 1'b1, 1'b0, a, d);
      chk("R4 bus off in pulse", {7'b0, dout_oe}, 8'h00);
    end
    drive(1'b1, 1'b1, 1'b1, 1'b0, a, d);
    drive(1'b1, 1'b1, 1'b0, 1'b0, a, d);
    shadow[a] = shadow[a] & d;
  endtask

  task automatic t_reset();
    read_at("R8 R1 erased a0", 0);
    read_at("R8 erased mid", 6'd33);
    read_at("R8 erased last", 6'(DEPTH - 1));
  endtask

  task automatic t_quiet_modes();
    drive(1'b0, 1'b1, 1'b0, 1'b0, 6'd3, 8'h00);
    chk("R2 disable oe", {7'b0, dout_oe}, 8'h00);
    chk("R10 disable bus zero", dout, 8'h00);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 6'd3, 8'h00);
    chk("R3 standby G low", {7'b0, dout_oe}, 8'h00);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd3, 8'h00);
    chk("R3 standby G high", {7'b0, dout_oe}, 8'h00);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 6'd3, 8'h00);
    chk("R6 inhibit oe", {7'b0, dout_oe}, 8'h00);
    repeat (3) drive(1'b1, 1'b1, 1'b1, 1'b0, 6'd3, 8'h00);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd3, 8'h00);
    read_at("R6 inhibit no write", 6'd3);
  endtask

  task automatic t_program();
    pulse(6'd5, 8'hA5, 1);
    read_at("R4 program a5", 6'd5);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 6'd5, 8'h00);
    chk("R5 verify oe", {7'b0, dout_oe}, 8'h01);
    chk("R5 verify data", dout, 8'hA5);
    pulse(6'd5, 8'h5F, 1);
    read_at("R9 reprogram and", 6'd5);
    chk("R9 value", shadow[5], 8'h05);
    read_at("R4 neighbour lo", 6'd4);
    read_at("R4 neighbour hi", 6'd6);
    pulse(6'(DEPTH - 1), 8'h00, 2);
    read_at("R4 last addr", 6'(DEPTH - 1));
  endtask

  task automatic t_long_pulse();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 6'd20, 8'h0F);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 6'd21, 8'h3C);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 6'd10, 8'hF0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 6'd10, 8'hF0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd10, 8'h00);
    shadow[10] = 8'hF0;
    read_at("R4 last cycle addr", 6'd10);
    read_at("R4 earlier addr 20 untouched", 6'd20);
    read_at("R4 earlier addr 21 untouched", 6'd21);
  endtask

  task automatic t_abort();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 6'd12, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 6'd12, 8'h00);
    chk("R11 hv idle oe", {7'b0, dout_oe}, 8'h00);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 6'd12, 8'h00);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd12, 8'h00);
    read_at("R11 abort by G", 6'd12);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 6'd13, 8'h00);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 6'd13, 8'h00);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 6'd13, 8'h00);
    read_at("R11 abort by supply", 6'd13);
  endtask

  task automatic t_signature();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 8'h00);
    chk("R7 sig oe", {7'b0, dout_oe}, 8'h01);
    chk("R7 sig even", dout, 8'h20);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 6'd1, 8'h00);
    chk("R7 sig odd", dout, 8'hB4);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 6'd62, 8'h00);
    chk("R7 upper bits ignored even", dout, 8'h20);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 6'd5, 8'h00);
    chk("R7 upper bits ignored odd", dout, 8'hB4);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 6'd1, 8'h00);
    chk("R3 sig flag in standby", {7'b0, dout_oe}, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_quiet_modes();
    t_program();
    t_long_pulse();
    t_abort();
    t_signature();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got=hang exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule